// File: doc/BRIEF.md
# Two-Read One-Write Latch Register File

This block is a small register file of eight words with one write port and two independent read ports. Each stored word sits in a level-sensitive master latch. The master opens for the location named by the write address while the clock is low, and it closes on the rising clock edge, which fixes the value. Each read port has its own address. That address picks a master, and the chosen value goes to a slave latch for that port.

Each slave latch is open while the clock is high and holds while the clock is low. The two latch stages open in opposite clock phases. A port that reads the location being written in the same cycle therefore sees the settled old value and never a half-written one. An active-low slave-enable input holds both slaves open in both clock phases. In that mode a port shows the master contents directly, which includes write data still passing through an open master.

The word width is a parameter. A wider instance behaves like several one-bit slices placed side by side, with every address and clock line shared between them. The block has no reset, and a location's contents are undefined until it has been written once. A write takes place in every clock cycle, to the location the write address selects.

Top module: `rf2r1w_latch`

## Requirements
- R1: There are 2**ADDR_W locations (eight by default). During a clock-low phase only the location selected by `wr_addr` can change, and every other location keeps its contents.
- R2: While `clk` is low, `wr_data` flows into the selected location. The value present at the rising edge stays stored through the following high phase and after it, until that location is selected again.
- R3: The two read ports are independent. Each may address any location in the same cycle as the other port and as the write, including the same location.
- R4: With `sle_n` = 1, each read output follows the stored value of its addressed location while `clk` is high. It holds the value it had at the falling edge for the whole low phase.
- R5: With `sle_n` = 0, both read outputs stay transparent in both clock phases. During the low phase, a port whose address equals `wr_addr` shows `wr_data`.
- R6: With `sle_n` = 1, a port that reads the location being written shows the old contents for the whole low phase. The new value appears in the next high phase.
- R7: Every bit of the data path is independent of the others. Patterns of all zeros, all ones, alternating bits and single bits are stored and returned unchanged on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Masters are open while it is low, slaves are open while it is high |
| sle_n | input | 1 | Active-low slave enable. When 0, both slave latches stay open |
| wr_addr | input | ADDR_W | Location written during the low phase |
| wr_data | input | DATA_W | Write data |
| rd_a_addr | input | ADDR_W | Read address of port A |
| rd_b_addr | input | ADDR_W | Read address of port B |
| rd_a_data | output | DATA_W | Port A read data from its slave latch |
| rd_b_data | output | DATA_W | Port B read data from its slave latch |

## Verification
A result is due in one of two phases. Read data for the current addresses appears within the same high phase, because the slave opens at once. A written value becomes stored at the next rising edge, and with the slaves latched it becomes visible only in the high phase after that edge. The bench changes every input in the middle of the high phase. It compares both ports against its reference array twice per cycle: shortly before the falling edge, which covers the transparent phase, and shortly before the rising edge, which covers the held or overridden phase. The reference array is updated only at the rising edge. It skips any location that has never been written.

// File: rtl/rf2r1w_pkg.sv
package rf2r1w_pkg;

    // Default geometry: eight locations of one byte each.
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_ADDR_W = 3;

    // Which phase opens a latch stage.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Number of locations that an address width can reach.
    function automatic int unsigned loc_count(input int unsigned aw);
        return 32'd1 << aw;
    endfunction

    // Open condition of a slave stage. It is open in the high phase, or
    // at all times while the active-low override is applied.
    function automatic logic slave_open(input logic clk_lvl, input logic en_n);
        return (clk_lvl == PH_HIGH) || !en_n;
    endfunction

    // Open condition of a master stage. It is open in the low phase, and
    // only for the location that is selected.
    function automatic logic master_open(input logic clk_lvl, input logic sel);
        return (clk_lvl == PH_LOW) && sel;
    endfunction

endpackage

// File: rtl/rf_write_demux.sv
module rf_write_demux
    import rf2r1w_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    localparam int unsigned NLOC  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NLOC-1:0]   wr_sel
);

    // One-hot select, one comparator per location.
    for (genvar i = 0; i < NLOC; i++) begin : g_dec
        assign wr_sel[i] = (wr_addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rf_latch_cell.sv
module rf_latch_cell
    import rf2r1w_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              sel,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Master stage: open while clk is low and this location is selected.
    // It closes when clk rises, which fixes the stored word.
    always_latch begin
        if (master_open(clk, sel)) begin
            q <= d;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf2r1w_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    localparam int unsigned NLOC  = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       sle_n,
    input  logic [NLOC-1:0][DATA_W-1:0] bank,
    input  logic [ADDR_W-1:0]          addr,
    output logic [DATA_W-1:0]          q
);

    logic [DATA_W-1:0] picked;

    // Read selector.
    always_comb begin
        picked = bank[addr];
    end

    // Slave stage: open in the high phase, or all the time when the
    // override is applied.
    always_latch begin
        if (slave_open(clk, sle_n)) begin
            q <= picked;
        end
    end

endmodule

// File: rtl/rf2r1w_latch.sv
module rf2r1w_latch
    import rf2r1w_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              sle_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int unsigned NLOC = 1 << ADDR_W;

    logic [NLOC-1:0]             wr_sel;
    logic [NLOC-1:0][DATA_W-1:0] bank_q;

    rf_write_demux #(.ADDR_W(ADDR_W)) u_demux (
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    // One master cell per location.
    for (genvar i = 0; i < NLOC; i++) begin : g_loc
        rf_latch_cell #(.DATA_W(DATA_W)) u_cell (
            .clk (clk),
            .sel (wr_sel[i]),
            .d   (wr_data),
            .q   (bank_q[i])
        );
    end

    rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_a (
        .clk   (clk),
        .sle_n (sle_n),
        .bank  (bank_q),
        .addr  (rd_a_addr),
        .q     (rd_a_data)
    );

    rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_b (
        .clk   (clk),
        .sle_n (sle_n),
        .bank  (bank_q),
        .addr  (rd_b_addr),
        .q     (rd_b_data)
    );

endmodule

// File: rtl/rf2r1w_latch_chk.sv
module rf2r1w_latch_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned NLOC  = 1 << ADDR_W
) (
    input logic                        clk,
    input logic                        sle_n,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [ADDR_W-1:0]           rd_a_addr,
    input logic [ADDR_W-1:0]           rd_b_addr,
    input logic [DATA_W-1:0]           rd_a_data,
    input logic [DATA_W-1:0]           rd_b_data,
    input logic [NLOC-1:0][DATA_W-1:0] bank_q
);

    // The block has no reset. The checks are held off until two rising
    // edges have passed, so that every snapshot below has been taken once.
    logic [1:0]                  edges = 2'd0;
    logic                        armed;
    logic [ADDR_W-1:0]           cap_addr;
    logic [DATA_W-1:0]           cap_data;
    logic [DATA_W-1:0]           snap_a;
    logic [DATA_W-1:0]           snap_b;
    logic [NLOC-1:0][DATA_W-1:0] bank_neg;

    assign armed = (edges == 2'd2);

    always_ff @(posedge clk) begin
        if (edges != 2'd2) edges <= edges + 2'd1;
        cap_addr <= wr_addr;
        cap_data <= wr_data;
    end

    always_ff @(negedge clk) begin
        snap_a   <= rd_a_data;
        snap_b   <= rd_b_data;
        bank_neg <= bank_q;
    end

    // R2: the word present at the rising edge is still stored at the
    // falling edge that follows.
    a_r2_capture_held: assert property (@(negedge clk) disable iff (!armed)
        bank_q[cap_addr] === cap_data);

    // R2: at the end of the low phase the selected master carries the
    // write data.
    a_r2_master_follows: assert property (@(posedge clk) disable iff (!armed)
        bank_q[wr_addr] === wr_data);

    // R1: locations that are not selected do not change during the low phase.
    for (genvar i = 0; i < NLOC; i++) begin : g_keep
        a_r1_unselected_kept: assert property (@(posedge clk) disable iff (!armed)
            (wr_addr != ADDR_W'(i)) |-> (bank_q[i] === bank_neg[i]));
    end

    // R4: at the end of the high phase each slave shows its addressed master.
    a_r4_port_a_transparent: assert property (@(negedge clk) disable iff (!armed)
        rd_a_data === bank_q[rd_a_addr]);
    a_r4_port_b_transparent: assert property (@(negedge clk) disable iff (!armed)
        rd_b_data === bank_q[rd_b_addr]);

    // R4, R6: with the override released, both ports hold through the low phase.
    a_r4_port_a_hold: assert property (@(posedge clk) disable iff (!armed)
        sle_n |-> (rd_a_data === snap_a));
    a_r4_port_b_hold: assert property (@(posedge clk) disable iff (!armed)
        sle_n |-> (rd_b_data === snap_b));

    // R5: with the override applied, the low phase shows the live masters.
    a_r5_override_a: assert property (@(posedge clk) disable iff (!armed)
        !sle_n |-> (rd_a_data === bank_q[rd_a_addr]));
    a_r5_override_b: assert property (@(posedge clk) disable iff (!armed)
        !sle_n |-> (rd_b_data === bank_q[rd_b_addr]));

endmodule

bind rf2r1w_latch rf2r1w_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .sle_n     (sle_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_b_addr (rd_b_addr),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .bank_q    (bank_q)
);

// File: tb/rf2r1w_latch_tb_top.sv
`timescale 1ns/1ps
module rf2r1w_latch_tb_top;

    localparam int unsigned DW   = 8;
    localparam int unsigned AW   = 3;
    localparam int unsigned NLOC = 1 << AW;

    logic          clk = 1'b1;
    logic          sle_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_a_addr = '0;
    logic [AW-1:0] rd_b_addr = '0;
    logic [DW-1:0] rd_a_data;
    logic [DW-1:0] rd_b_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference array and a record of which locations have been written.
    logic [DW-1:0] mdl [NLOC];
    bit            known [NLOC];

    // 50 MHz clock. It starts high, so the first rising edge is at 20 ns.
    always #10 clk = ~clk;

    rf2r1w_latch #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .sle_n     (sle_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // One clock cycle. The task is entered in the middle of the high phase.
    task automatic cycle(input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                         input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                         input logic sle, input string req);
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        bit            ka;
        bit            kb;
        wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb; sle_n = sle;
        // End of the high phase: each slave is open and the masters are closed (R3, R4).
        #3;
        if (known[ra]) chk({req, " R4 high A"}, rd_a_data, mdl[ra]);
        if (known[rb]) chk({req, " R3 high B"}, rd_b_data, mdl[rb]);
        // End of the low phase: the ports hold (R4, R6) or follow the override (R5).
        #10;
        if (sle) begin
            ea = mdl[ra]; ka = known[ra];
            eb = mdl[rb]; kb = known[rb];
        end else begin
            ea = (ra == wa) ? wd : mdl[ra]; ka = (ra == wa) || known[ra];
            eb = (rb == wa) ? wd : mdl[rb]; kb = (rb == wa) || known[rb];
        end
        if (ka) chk({req, sle ? " R6 low A" : " R5 low A"}, rd_a_data, ea);
        if (kb) chk({req, sle ? " R4 low B" : " R5 low B"}, rd_b_data, eb);
        // Rising edge: the reference stores the word (R1, R2).
        #2;
        mdl[wa]   = wd;
        known[wa] = 1'b1;
        #5;
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NLOC; i++) begin
            mdl[i] = '0;
            known[i] = 1'b0;
        end
        #5;
        // Fill every location with a distinct pattern (R1, R2).
        for (int i = 0; i < NLOC; i++)
            cycle(AW'(i), DW'(8'h11 * (i + 1)), AW'(i), AW'(NLOC - 1 - i), 1'b1, "fill R1");
        // Read back every location on both ports and overwrite other locations meanwhile.
        for (int i = 0; i < NLOC; i++)
            cycle(AW'(i + 4), DW'(8'hA0 + i), AW'(i), AW'(i + 1), 1'b1, "readback R2");
        // Width patterns (R7).
        cycle(3'd2, 8'h00, 3'd0, 3'd1, 1'b1, "pat R7");
        cycle(3'd3, 8'hFF, 3'd2, 3'd2, 1'b1, "pat R7");
        cycle(3'd4, 8'h55, 3'd3, 3'd2, 1'b1, "pat R7");
        cycle(3'd5, 8'hAA, 3'd4, 3'd3, 1'b1, "pat R7");
        for (int b = 0; b < DW; b++)
            cycle(AW'(b), DW'(1) << b, AW'(b + 7), AW'(b + 6), 1'b1, "walk R7");
        // Same location read and written with the slaves latched (R6).
        cycle(3'd6, 8'h3C, 3'd6, 3'd6, 1'b1, "same R6");
        cycle(3'd6, 8'hC3, 3'd6, 3'd1, 1'b1, "same R6");
        cycle(3'd1, 8'h77, 3'd6, 3'd1, 1'b1, "same R6");
        // Override applied: the ports see write data in flight (R5).
        cycle(3'd0, 8'h5A, 3'd0, 3'd7, 1'b0, "ovr R5");
        cycle(3'd7, 8'hE1, 3'd0, 3'd7, 1'b0, "ovr R5");
        cycle(3'd2, 8'h9B, 3'd2, 3'd2, 1'b0, "ovr R5");
        cycle(3'd2, 8'h10, 3'd3, 3'd2, 1'b1, "ovr-off R4");
        // Pseudo-random traffic across every mode (R1..R7).
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[2:0], lfsr[15:8], lfsr[5:3], lfsr[8:6], lfsr[11] | lfsr[12], "rand R3");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule